// File: doc/BRIEF.md
# TDM Time-Slot Interchange Switch

This block moves bytes between time slots of parallel TDM streams. There are two input sides, called backplane and local, and each carries `NSTR` streams of `NCH` channels. Serial-to-parallel conversion happens outside the block. Each clock cycle is one channel time, and a `frame_sync` pulse marks channel 0. Every byte that arrives is stored in a per-side data memory. That memory is double-buffered by frame, so a frame being written never disturbs the frame being read.

There are two output sides, and each has its own connection memory with one 16-bit entry per output stream and channel. In connection mode, the entry names a source side, stream and channel, and the output carries the byte that source received in the previous frame. In message mode, the output carries the entry's low byte on that channel in every frame.

A microprocessor writes and reads the connection memory through a plain register port. A write is staged and reaches the switching logic only at the next frame boundary.

Top module: `tsi_switch`

## Requirements
- R1: After reset, every connection entry reads 16'h80FF (message mode, idle byte FF), so every output byte is 8'hFF until a programmed entry becomes active.
- R2: A write with `cpu_we` high stores `cpu_wdata` at `cpu_addr`. The address is split as [7] output side (0 backplane, 1 local), [6:5] output stream and [4:0] output channel. The value can be read back on `cpu_rdata` from the next cycle.
- R3: When entry bit 15 is 0, the output byte is the byte received in the previous frame on the source given by the entry: bit 14 is the side (0 backplane, 1 local), bits 13:12 are the stream and bits 4:0 are the channel.
- R4: When entry bit 15 is 1, the output byte equals entry bits 7:0, and it repeats in every frame.
- R5: A write takes effect from the next `frame_sync` cycle. This includes a write made in a `frame_sync` cycle itself. No output changes its source or mode partway through a frame.
- R6: Either output side can take data from either input side. Any number of outputs may share the same source.
- R7: The cycle with `frame_sync` high is channel 0, and each following cycle is the next channel.
- R8: The delay through the switch is exactly one frame. Data from two frames earlier never appears on an output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one channel per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_sync | input | 1 | High in the channel-0 cycle of each frame |
| in_bp | input | NSTR*8 | Backplane input bytes, stream s in bits [8s+7:8s] |
| in_lc | input | NSTR*8 | Local input bytes |
| out_bp | output | NSTR*8 | Backplane output bytes |
| out_lc | output | NSTR*8 | Local output bytes |
| cpu_we | input | 1 | Connection memory write strobe |
| cpu_addr | input | 8 | Connection entry address {side, stream, channel} |
| cpu_wdata | input | 16 | Entry write value |
| cpu_rdata | output | 16 | Entry read value (staged copy) |

## Verification
A processor write to the connection memory can land in the very cycle where the frame boundary copies the staged entries into the active set. The bench provokes this by placing the first write of every write burst in the `frame_sync` cycle. It then compares every output channel of the frame that follows against a model. In that model, the active copy is taken before the write is applied, so the new entry must appear only one frame later. A per-frame input pattern tells the previous frame apart from the one before it, which exposes any bank swap error.

// File: rtl/tsi_switch.sv
module tsi_switch #(
  parameter int NSTR = 4,
  parameter int NCH  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_sync,
  input  logic [NSTR*8-1:0] in_bp,
  input  logic [NSTR*8-1:0] in_lc,
  output logic [NSTR*8-1:0] out_bp,
  output logic [NSTR*8-1:0] out_lc,
  input  logic              cpu_we,
  input  logic [7:0]        cpu_addr,
  input  logic [15:0]       cpu_wdata,
  output logic [15:0]       cpu_rdata
);
  localparam int SW = $clog2(NSTR);
  localparam int CW = $clog2(NCH);
  localparam int NE = NSTR * NCH;
  localparam int AW = 1 + SW + CW;

  logic [CW-1:0] ch_q, cur_ch;
  logic          bank_q, cur_bank;
  logic [7:0]    dm_bp [2][NE];
  logic [7:0]    dm_lc [2][NE];
  logic [15:0]   shd [2*NE];
  logic [2*NE-1:0][15:0] act;

  assign cur_ch   = frame_sync ? '0 : ch_q;
  assign cur_bank = frame_sync ? ~bank_q : bank_q;
  assign cpu_rdata = shd[cpu_addr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ch_q   <= '0;
      bank_q <= 1'b0;
    end else begin
      ch_q   <= cur_ch + 1'b1;
      bank_q <= cur_bank;
    end
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < NSTR; s++) begin
      dm_bp[cur_bank][{SW'(s), cur_ch}] <= in_bp[s*8 +: 8];
      dm_lc[cur_bank][{SW'(s), cur_ch}] <= in_lc[s*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2*NE; i++) begin
        shd[i] <= 16'h80FF;
        act[i] <= 16'h80FF;
      end
    end else begin
      if (cpu_we) shd[cpu_addr[AW-1:0]] <= cpu_wdata;
      if (frame_sync)
        for (int i = 0; i < 2*NE; i++) act[i] <= shd[i];
    end
  end

  for (genvar o = 0; o < 2; o++) begin : g_side
    for (genvar s = 0; s < NSTR; s++) begin : g_str
      logic [AW-1:0]    ix;
      logic [15:0]      e;
      logic [SW+CW-1:0] src;
      logic [7:0]       rd, ob;
      assign ix  = {1'(o), SW'(s), cur_ch};
      assign e   = frame_sync ? shd[ix] : act[ix];
      assign src = {e[12 +: SW], e[CW-1:0]};
      assign rd  = e[14] ? dm_lc[~cur_bank][src] : dm_bp[~cur_bank][src];
      assign ob  = e[15] ? e[7:0] : rd;
      if (o == 0) begin : g_bp
        assign out_bp[s*8 +: 8] = ob;
      end else begin : g_lc
        assign out_lc[s*8 +: 8] = ob;
      end
    end
  end

  // R7
  frame_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |=> (ch_q == CW'(1)));

  // R8
  bank_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |=> (bank_q != $past(bank_q)));

  // R5
  midframe_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_sync |=> $stable(act));

  // R2
  write_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cpu_we) && cpu_addr == $past(cpu_addr)) |-> cpu_rdata == $past(cpu_wdata));

  // R1
  idle_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (out_bp == '1 && out_lc == '1));
endmodule

// File: tb/tb_tsi_switch.sv
module tb_tsi_switch;
  localparam int NSTR = 4;
  localparam int NCH  = 32;
  localparam int NV   = 10;
  // {address, entry}: address {side, stream, channel}
  localparam logic [23:0] VEC [NV] = '{
    {8'h00, 16'h0005},  // bp s0 c0  <- bp s0 c5
    {8'h3F, 16'h101F},  // bp s1 c31 <- bp s1 c31
    {8'h45, 16'h4000},  // bp s2 c5  <- lc s0 c0 (cross)
    {8'h67, 16'h80A5},  // bp s3 c7  message A5
    {8'h80, 16'h701F},  // lc s0 c0  <- lc s3 c31
    {8'hA3, 16'h0005},  // lc s1 c3  <- bp s0 c5 (fan-out)
    {8'hDF, 16'h2011},  // lc s2 c31 <- bp s2 c17 (cross)
    {8'hE0, 16'h805A},  // lc s3 c0  message 5A
    {8'hE1, 16'h0000},  // lc s3 c1  <- bp s0 c0 (message off)
    {8'h1E, 16'h600A}   // bp s0 c30 <- lc s2 c10
  };

  logic clk = 0, rst_n = 0, frame_sync = 0, cpu_we = 0;
  logic [NSTR*8-1:0] in_bp = '0, in_lc = '0, out_bp, out_lc;
  logic [7:0] cpu_addr = '0;
  logic [15:0] cpu_wdata = '0, cpu_rdata;
  int checks = 0, fails = 0;
  logic [15:0] mshd [256];
  logic [15:0] mact [256];

  tsi_switch #(.NSTR(NSTR), .NCH(NCH)) dut (.*);

  always #10 clk = ~clk;

  function automatic logic [7:0] pat(int side, int s, int f, int c);
    if (f < 0) return 8'h00;
    return 8'(side*131 + s*29 + c*7 + f*53 + 1);
  endfunction

  task automatic chk(string req, logic [31:0] act_v, logic [31:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act_v, exp_v);
    end
  endtask

  // mode 0 idle, 1 write table (mask xor on entry), 2 read back
  task automatic run_frame(int f, int mode, logic [15:0] xm);
    for (int c = 0; c < NCH; c++) begin
      @(negedge clk);
      if (c == 0) for (int i = 0; i < 256; i++) mact[i] = mshd[i];
      frame_sync = (c == 0);
      for (int s = 0; s < NSTR; s++) begin
        in_bp[s*8 +: 8] = pat(0, s, f, c);
        in_lc[s*8 +: 8] = pat(1, s, f, c);
      end
      cpu_we = (mode == 1) && (c < NV);
      if (c < NV) begin
        cpu_addr  = VEC[c][23:16];
        cpu_wdata = VEC[c][15:0] ^ xm;
      end
      #2;
      for (int o = 0; o < 2; o++)
        for (int s = 0; s < NSTR; s++) begin
          logic [15:0] e;
          logic [7:0] ex, ac;
          e  = mact[o*128 + s*32 + c];
          ex = e[15] ? e[7:0] : pat(int'(e[14]), int'(e[13:12]), f-1, int'(e[4:0]));
          ac = (o == 0) ? out_bp[s*8 +: 8] : out_lc[s*8 +: 8];
          // R3 R6 R8 for connection entries, R4 for message entries, R5 via staged model
          chk(e[15] ? "R4 message" : "R3 R6 R8 connection", {24'h0, ac}, {24'h0, ex});
        end
      if (mode == 2 && c < NV)
        chk("R2 readback", {16'h0, cpu_rdata}, {16'h0, mshd[cpu_addr]});
      if (cpu_we) mshd[cpu_addr] = cpu_wdata;
    end
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mshd[i] = 16'h80FF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    cpu_addr = 8'hA3;
    #1;
    // R1 reset state
    chk("R1 entry", {16'h0, cpu_rdata}, 32'h80FF);
    chk("R1 out", {out_bp, out_lc}, '1);
    run_frame(0, 0, 16'h0);
    run_frame(1, 1, 16'h0);   // writes land, still idle this frame (R5)
    run_frame(2, 2, 16'h0);   // connections live, readback R2
    run_frame(3, 0, 16'h0);   // R7 R8 steady
    run_frame(4, 1, 16'h8000);// flip modes; first write in sync cycle (R5)
    run_frame(5, 2, 16'h8000);
    run_frame(6, 1, 16'h0);
    run_frame(7, 0, 16'h0);
    // R1 directed: reset again restores idle
    @(negedge clk);
    frame_sync = 0; cpu_we = 0;
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    cpu_addr = 8'h45;
    #1;
    chk("R1 reentry", {16'h0, cpu_rdata}, 32'h80FF);
    chk("R1 reout", {out_bp, out_lc}, '1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule